// File: doc/BRIEF.md
# Oversampled I2C Target Byte Engine

This block is an I2C target that runs entirely on a fast system clock. SCL and SDA pass through a two-flop synchronizer and one more history flop, so that bus events come from comparing two registered samples and nothing is clocked by the bus lines themselves. A START always puts the block into address-compare mode, whatever it was doing. A STOP always sends it back to idle, even a STOP that comes in the same SCL high period as a START. While idle, or after an address that is not its own, the block ignores all SCL and SDA activity until the next START.

Once its 7-bit address matches, the block serves an unbroken stream of bytes to or from a local device, for example a display controller. At the rising edge of the ninth SCL pulse of every byte it emits a one-cycle strobe. A write strobe comes with the received byte on `wr_data`. A read strobe asks the device for the next byte on `rd_data`, which the block loads at the following SCL falling event. The block pulls SDA low through the open-drain enable `sda_oe` to ACK and to send read data.

Top module: `i2c_target_stream`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sda_oe`, `wr_strobe` and `rd_strobe` are low. The block starts in idle and ignores bus traffic until a START.
- R2: A START (SDA falling while SCL is high) moves the block to address-compare mode from any state, including the middle of a data byte. Any partially received bits are discarded.
- R3: The first byte after a START is received MSB first. Bits 7..1 are the address and bit 0 is the direction (1 = read). When bits 7..1 equal `own_addr`, `sda_oe` is high throughout the ninth SCL high period of that byte (ACK).
- R4: When the address does not match, the block never drives `sda_oe` and emits no strobe until the next START.
- R5: In write mode, each data byte is received MSB first and ACKed in its ninth clock. At the ninth SCL rising event, `wr_strobe` pulses for exactly one cycle while `wr_data` holds the byte. The two strobes never coincide.
- R6: `rd_strobe` pulses for one cycle at the ninth SCL rising event of a matched read address, and again after each read byte the controller ACKs (SDA low in the ninth clock). The block loads `rd_data` at the next SCL falling event and sends it MSB first, with `sda_oe` equal to the inverse of each bit.
- R7: A NACK (SDA high in the ninth clock of a read byte) makes the block release SDA, emit no strobe and return to idle, so that later clock pulses read as all ones.
- R8: A STOP (SDA rising while SCL is high) returns the block to idle from any state. This includes a STOP in the middle of a byte and a STOP in the same SCL high period as a START. SCL toggling after a STOP is ignored until a new START.
- R9: `sda_oe` changes only after an SCL falling event, so it stays constant while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND bus) |
| sda_oe | output | 1 | High pulls SDA low |
| own_addr | input | 7 | Address the block answers to |
| wr_data | output | 8 | Last byte written by the controller |
| wr_strobe | output | 1 | One-cycle pulse: new byte on wr_data |
| rd_data | input | 8 | Next byte to send to the controller |
| rd_strobe | output | 1 | One-cycle pulse: supply the next read byte |

## Verification
The address path is swept over all 128 address values, each followed by a data byte derived from the address. This shows that the block answers to exactly one address and that a mismatch silences the whole transaction. A multi-byte write stream with edge patterns (all zeros, all ones, alternating ends) and a read stream that ends in a NACK show that bit order, strobe count and the hand-off from the device are right. Separate sequences abort the transfer at unusual points: a STOP mid-byte, a START and STOP in one SCL high period, and a repeated START mid-byte. Each of these tells a block that truly resets on these conditions apart from one that resumes counting where it left off.

// File: rtl/i2c_target_stream.sv
module i2c_target_stream (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [6:0] own_addr,
  output logic [7:0] wr_data,
  output logic       wr_strobe,
  input  logic [7:0] rd_data,
  output logic       rd_strobe
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WRITE, S_READ, S_SKIP} state_t;

  state_t     state;
  logic [2:0] scl_sh, sda_sh;
  logic [3:0] cnt;
  logic [7:0] sr, tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_in};
      sda_sh <= {sda_sh[1:0], sda_in};
    end
  end

  wire scl_now   = scl_sh[1];
  wire scl_old   = scl_sh[2];
  wire sda_now   = sda_sh[1];
  wire sda_old   = sda_sh[2];
  wire scl_rise  = scl_now & ~scl_old;
  wire scl_fall  = ~scl_now & scl_old;
  wire scl_high  = scl_now & scl_old;
  wire start_ev  = scl_high & sda_old & ~sda_now;
  wire stop_ev   = scl_high & ~sda_old & sda_now;
  wire ninth     = (cnt == 4'd8);
  wire addr_hit  = (sr[7:1] == own_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sr        <= '0;
      tx        <= '0;
      sda_oe    <= 1'b0;
      wr_data   <= '0;
      wr_strobe <= 1'b0;
      rd_strobe <= 1'b0;
    end else begin
      wr_strobe <= 1'b0;
      rd_strobe <= 1'b0;
      if (start_ev) begin
        state  <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state  <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WRITE: begin
            if (scl_rise) begin
              if (!ninth) begin
                sr  <= {sr[6:0], sda_now};
                cnt <= cnt + 4'd1;
              end else begin
                cnt <= '0;
                if (state == S_WRITE) begin
                  wr_strobe <= 1'b1;
                  wr_data   <= sr;
                end else if (!addr_hit) begin
                  state <= S_SKIP;
                end else if (sr[0]) begin
                  state     <= S_READ;
                  rd_strobe <= 1'b1;
                end else begin
                  state <= S_WRITE;
                end
              end
            end else if (scl_fall) begin
              sda_oe <= ninth && (state == S_WRITE || addr_hit);
            end
          end
          S_READ: begin
            if (scl_rise) begin
              if (!ninth) begin
                cnt <= cnt + 4'd1;
              end else begin
                cnt <= '0;
                if (sda_now) state <= S_IDLE;
                else         rd_strobe <= 1'b1;
              end
            end else if (scl_fall) begin
              if (cnt == 4'd0) begin
                sda_oe <= ~rd_data[7];
                tx     <= {rd_data[6:0], 1'b0};
              end else if (!ninth) begin
                sda_oe <= ~tx[7];
                tx     <= {tx[6:0], 1'b0};
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_target_stream_chk.sv
module i2c_target_stream_chk (
  input logic clk,
  input logic rst,
  input logic scl_in,
  input logic sda_oe,
  input logic wr_strobe,
  input logic rd_strobe
);

  logic [1:0] scl_cp;

  always_ff @(posedge clk) begin
    if (rst) scl_cp <= 2'b11;
    else     scl_cp <= {scl_cp[0], scl_in};
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!sda_oe && !wr_strobe && !rd_strobe));

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> !wr_strobe);

  // R5
  wr_on_high_chk: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> $past(scl_cp[1]));

  // R5
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_strobe && rd_strobe));

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> !rd_strobe);

  // R9
  oe_moves_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_cp[1]));

endmodule

bind i2c_target_stream i2c_target_stream_chk u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe),
  .wr_strobe(wr_strobe), .rd_strobe(rd_strobe)
);

// File: tb/test_i2c_target_stream.sv
module test_i2c_target_stream;
  localparam int Q = 5;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic sda_oe, wr_strobe, rd_strobe;
  logic [7:0] wr_data, rd_data;
  wire sda_bus = sda_drv & ~sda_oe;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_idx = 0;
  logic [7:0] last_wr = '0;

  always #4 clk = ~clk;

  i2c_target_stream i_i2c_target_stream (
    .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_bus),
    .sda_oe(sda_oe), .own_addr(OWN), .wr_data(wr_data),
    .wr_strobe(wr_strobe), .rd_data(rd_data), .rd_strobe(rd_strobe)
  );

  function automatic logic [7:0] rbyte(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  assign rd_data = rbyte(rd_idx);

  always @(posedge clk) begin
    if (wr_strobe) begin wr_cnt <= wr_cnt + 1; last_wr <= wr_data; end
    if (rd_strobe) rd_idx <= rd_idx + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s0, output logic s1);
    sda_drv = b; wq();
    scl_drv = 1'b1; wq();
    s0 = sda_bus; wq();
    s1 = sda_bus;
    scl_drv = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b1; wq();
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic s0, s1;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s0, s1);
    clk_bit(1'b1, s0, s1);
    ack = ~s0;
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] d, output logic steady);
    logic s0, s1;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s0, s1);
      d[i] = s0;
      if (s0 != s1) steady = 1'b0;
    end
    clk_bit(nack, s0, s1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic ack, steady, s0, s1;
    logic [7:0] d;
    int base, cnt0;

    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0 && wr_strobe == 1'b0 && rd_strobe == 1'b0, "R1 reset outputs",
        int'({sda_oe, wr_strobe, rd_strobe}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sda_oe == 1'b0 && wr_strobe == 1'b0 && rd_strobe == 1'b0, "R1 after reset",
        int'({sda_oe, wr_strobe, rd_strobe}), 0);
    write_byte({OWN, 1'b0}, ack);
    chk(ack == 1'b0, "R1 idle ignores traffic", int'(ack), 0);
    bus_stop();

    // R3 R4 R5: sweep every address
    for (int a = 0; a < 128; a++) begin
      logic exp;
      logic [7:0] dv;
      exp = (a == int'(OWN));
      dv = 8'(a) ^ 8'h3C;
      cnt0 = wr_cnt;
      bus_start();
      write_byte({7'(a), 1'b0}, ack);
      chk(ack == exp, "R3/R4 address ack", int'(ack), int'(exp));
      write_byte(dv, ack);
      chk(ack == exp, "R4/R5 data ack", int'(ack), int'(exp));
      bus_stop();
      chk(wr_cnt == cnt0 + int'(exp), "R4/R5 strobe count", wr_cnt, cnt0 + int'(exp));
      if (exp) chk(last_wr == dv, "R5 wr_data", int'(last_wr), int'(dv));
    end

    // R5: write stream
    bus_start();
    write_byte({OWN, 1'b0}, ack);
    chk(ack, "R3 stream address ack", int'(ack), 1);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v;
      v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h81 : 8'h6E;
      cnt0 = wr_cnt;
      write_byte(v, ack);
      chk(ack, "R5 stream ack", int'(ack), 1);
      chk(wr_cnt == cnt0 + 1, "R5 one strobe per byte", wr_cnt, cnt0 + 1);
      chk(last_wr == v, "R5 stream byte", int'(last_wr), int'(v));
    end
    bus_stop();

    // R6 R7 R9: read stream ending in NACK
    base = rd_idx;
    bus_start();
    write_byte({OWN, 1'b1}, ack);
    chk(ack, "R3 read address ack", int'(ack), 1);
    chk(rd_idx == base + 1, "R6 strobe on read address", rd_idx, base + 1);
    for (int k = 1; k <= 4; k++) begin
      read_byte(k == 4, d, steady);
      chk(d == rbyte(base + k), "R6 read byte", int'(d), int'(rbyte(base + k)));
      chk(steady, "R9 sda steady while scl high", int'(steady), 1);
    end
    chk(rd_idx == base + 4, "R7 no strobe after NACK", rd_idx, base + 4);
    chk(sda_oe == 1'b0, "R7 release after NACK", int'(sda_oe), 0);
    read_byte(1'b1, d, steady);
    chk(d == 8'hFF, "R7 idle after NACK", int'(d), 255);
    bus_stop();

    // R8: STOP mid-byte, then clocks without START
    cnt0 = wr_cnt;
    bus_start();
    write_byte({OWN, 1'b0}, ack);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, s0, s1);
    bus_stop();
    write_byte({OWN, 1'b0}, ack);
    chk(ack == 1'b0, "R8 ignore after mid-byte STOP", int'(ack), 0);
    write_byte(8'h11, ack);
    chk(ack == 1'b0 && wr_cnt == cnt0, "R8 no strobe after STOP", wr_cnt, cnt0);

    // R8: START and STOP in one SCL high period
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b0; wq();
    sda_drv = 1'b1; wq();
    scl_drv = 1'b0; wq();
    write_byte({OWN, 1'b0}, ack);
    chk(ack == 1'b0, "R8 START+STOP leaves idle", int'(ack), 0);
    bus_stop();

    // R2: repeated START mid-byte
    bus_start();
    write_byte({OWN, 1'b0}, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s0, s1);
    cnt0 = wr_cnt;
    bus_start();
    write_byte({OWN, 1'b0}, ack);
    chk(ack, "R2 address after repeated START", int'(ack), 1);
    write_byte(8'hC3, ack);
    chk(ack && last_wr == 8'hC3, "R2 clean byte after repeated START", int'(last_wr), 195);
    chk(wr_cnt == cnt0 + 1, "R2 single strobe", wr_cnt, cnt0 + 1);
    bus_stop();

    finish_run();
  end
endmodule